// File: doc/BRIEF.md
# Byte Serial Device Register Front End

This block is the processor-facing register set of a byte-oriented serial device. Software sees four word locations on a small bus. One location reads back a four-flag status word and, when written, acts as a write-1-to-clear action word. One location accepts bytes for transmission, one returns received bytes, and one holds an interrupt enable mask. Behind the registers sit two small byte queues, one per direction.

The line serializer is not part of the block. Its transmit side takes bytes with a one-cycle `dev_tx_pop` strobe and sees the oldest queued byte on `dev_tx_data`. Its receive side delivers bytes with a one-cycle `dev_rx_push` strobe. A pop from an empty transmit queue and a push into a full receive queue are both recorded as sticky error flags. The interrupt line is the OR of every status flag that its enable bit allows.

Top module: `byte_link_regs`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), the status word reads 0x01 (only transmit-room set), the enable mask reads 0x00, both queues are empty and irq is low.
- R2: The address map is: 0 reads status and writes the action word; 1 writes the transmit queue and reads 0x00; 2 reads the receive queue; 3 reads and writes the enable mask in bits 3:0. Status bits are 0 transmit-room, 1 receive-data, 2 transmit-underrun, 3 receive-overrun; bits 7:4 of status and mask read 0. Read data is valid in the cycle of the read.
- R3: Status bit 0 is low in the cycle after a write to address 1 or a write of 1 to action bit 0; in any other cycle it equals "transmit queue not full" as of the previous clock edge.
- R4: The transmit queue is first-in first-out with TXQ_DEPTH entries: `dev_tx_data` shows the oldest byte, `dev_tx_pop` removes it, and a write to address 1 while the queue is full is discarded.
- R5: Status bit 1 is low in the cycle after a read of address 2 that takes a byte or a write of 1 to action bit 1; in any other cycle it equals "receive queue not empty" as of the previous clock edge.
- R6: A `dev_tx_pop` while the transmit queue is empty sets status bit 2 at the next clock edge and removes nothing.
- R7: A `dev_rx_push` while the receive queue holds RXQ_DEPTH bytes sets status bit 3 at the next clock edge and the byte is discarded; reads return the earlier bytes in arrival order.
- R8: Status bits 2 and 3 remain set until a write to address 0 with a 1 in the matching bit; writing 0 there leaves them unchanged.
- R9: When an error event and a write-1 clear of the same error bit fall in one cycle, the bit is set after that edge.
- R10: irq is high exactly while some status bit and its enable mask bit are both 1.
- R11: A read of address 2 while the receive queue is empty returns 0x00 and changes no status bit and no queue state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| bus_sel | input | 1 | Bus access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Word address of the access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid in the access cycle |
| irq | output | 1 | Interrupt request, level |
| dev_tx_pop | input | 1 | Serializer takes one transmit byte |
| dev_tx_data | output | 8 | Oldest byte in the transmit queue |
| dev_rx_push | input | 1 | Serializer delivers one received byte |
| dev_rx_data | input | 8 | Byte delivered with dev_rx_push |

## Verification
The functions that can collide are a hardware error event and a software write-1 clear of the same sticky flag. The bench provokes this by asserting `dev_tx_pop` on an empty transmit queue in the very cycle that writes 0x04 to address 0, and by pushing into a full receive queue while writing 0x08 there; the flag must read back as set afterwards and only a later lone clear may drop it. The automatic clear of the data flags on a queue access is likewise judged against the flag's return one cycle later.

// File: rtl/byte_link_pkg.sv
// Package: shared constants and types for the byte serial register front end.
// Assumes a 2-bit word address bus and 8-bit data.
package byte_link_pkg;

    localparam int unsigned BUS_AW  = 2;
    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned NFLAGS  = 4;

    // Register locations; the status/action sharing of location 0 is behaviour.
    typedef enum logic [BUS_AW-1:0] {
        LOC_CTRL = 2'd0,
        LOC_TXQ  = 2'd1,
        LOC_RXQ  = 2'd2,
        LOC_MASK = 2'd3
    } loc_e;

    // Flag word, most significant field first so that bit 0 is tx_room.
    typedef struct packed {
        logic rx_over;
        logic tx_under;
        logic rx_avail;
        logic tx_room;
    } flags_t;

    localparam flags_t FLAGS_RESET = '{rx_over: 1'b0, tx_under: 1'b0,
                                       rx_avail: 1'b0, tx_room: 1'b1};

endpackage

// File: rtl/byte_link_fifo.sv
// Module: byte_link_fifo
// Small first-in first-out byte queue with occupancy count.
// Assumes DEPTH is a power of two, at least 2. A push while full and a pop
// while empty are ignored; a push and pop in the same cycle are both honoured
// when each is legal on its own.
module byte_link_fifo #(
    parameter int unsigned WIDTH = 8,
    parameter int unsigned DEPTH = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [WIDTH-1:0] push_data,
    input  logic             pop,
    output logic [WIDTH-1:0] head,
    output logic             empty,
    output logic             full
);

    localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CNT_W = $clog2(DEPTH + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(DEPTH);

    logic [WIDTH-1:0] slot [DEPTH];
    logic [PTR_W-1:0] wr_ptr;
    logic [PTR_W-1:0] rd_ptr;
    logic [CNT_W-1:0] count;
    logic             push_ok;
    logic             pop_ok;

    // Qualify requests against the current occupancy.
    always_comb begin
        push_ok = push && (count != CNT_FULL);
        pop_ok  = pop && (count != '0);
    end

    // One storage process per slot, written only when the write pointer lands on it.
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                slot[i] <= '0;
            end else if (push_ok && (wr_ptr == PTR_W'(i))) begin
                slot[i] <= push_data;
            end
        end
    end

    // Advance the pointers and the occupancy count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (push_ok) begin
                wr_ptr <= wr_ptr + 1'b1;
            end
            if (pop_ok) begin
                rd_ptr <= rd_ptr + 1'b1;
            end
            case ({push_ok, pop_ok})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    // Present the oldest entry and the occupancy flags.
    always_comb begin
        head  = slot[rd_ptr];
        empty = (count == '0);
        full  = (count == CNT_FULL);
    end

endmodule

// File: rtl/byte_link_flags.sv
// Module: byte_link_flags
// Holds the four status flags. The two data flags drop for one cycle on a
// queue access or a write-1 clear and then follow queue state; the two error
// flags are sticky, set by hardware events and cleared only by write-1, with
// a same-cycle set taking priority over the clear.
// Assumes clr is already qualified by a write to the action location.
module byte_link_flags
    import byte_link_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   tx_written,
    input  logic   rx_taken,
    input  flags_t clr,
    input  logic   tx_full,
    input  logic   rx_empty,
    input  logic   under_evt,
    input  logic   over_evt,
    output flags_t flags
);

    flags_t flags_d;

    // Compute the next flag word from events, clears and queue state.
    always_comb begin
        flags_d.tx_room  = (tx_written || clr.tx_room)  ? 1'b0 : !tx_full;
        flags_d.rx_avail = (rx_taken   || clr.rx_avail) ? 1'b0 : !rx_empty;
        flags_d.tx_under = under_evt || (flags.tx_under && !clr.tx_under);
        flags_d.rx_over  = over_evt  || (flags.rx_over  && !clr.rx_over);
    end

    // Register the flag word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags <= FLAGS_RESET;
        end else begin
            flags <= flags_d;
        end
    end

endmodule

// File: rtl/byte_link_regs.sv
// Module: byte_link_regs (top)
// Register front end of a byte serial device: decodes single-cycle bus
// accesses, feeds the transmit and receive queues, keeps the status flags and
// drives a masked level interrupt. Assumes one access per bus_sel cycle and
// single-cycle device strobes.
module byte_link_regs
    import byte_link_pkg::*;
#(
    parameter int unsigned TXQ_DEPTH = 4,
    parameter int unsigned RXQ_DEPTH = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [BUS_AW-1:0] bus_addr,
    input  logic [BYTE_W-1:0] bus_wdata,
    output logic [BYTE_W-1:0] bus_rdata,
    output logic              irq,
    input  logic              dev_tx_pop,
    output logic [BYTE_W-1:0] dev_tx_data,
    input  logic              dev_rx_push,
    input  logic [BYTE_W-1:0] dev_rx_data
);

    localparam int unsigned PAD_W = BYTE_W - NFLAGS;

    logic              wr_ctrl;
    logic              wr_txq;
    logic              wr_mask;
    logic              rd_any;
    logic              rd_rxq;
    logic              tx_empty;
    logic              tx_full;
    logic              rx_empty;
    logic              rx_full;
    logic              tx_pop_ok;
    logic              rx_pop_ok;
    logic              under_evt;
    logic              over_evt;
    logic [BYTE_W-1:0] rx_head;
    logic [NFLAGS-1:0] mask;
    logic [NFLAGS-1:0] status_bits;
    flags_t            flags;
    flags_t            clr;

    // Decode the bus access into per-location strobes.
    always_comb begin
        wr_ctrl = bus_sel && bus_wr  && (bus_addr == LOC_CTRL);
        wr_txq  = bus_sel && bus_wr  && (bus_addr == LOC_TXQ);
        wr_mask = bus_sel && bus_wr  && (bus_addr == LOC_MASK);
        rd_any  = bus_sel && !bus_wr;
        rd_rxq  = rd_any && (bus_addr == LOC_RXQ);
        clr     = wr_ctrl ? flags_t'(bus_wdata[NFLAGS-1:0]) : '0;
    end

    // Derive queue handshakes and error events from the device strobes.
    always_comb begin
        tx_pop_ok = dev_tx_pop && !tx_empty;
        under_evt = dev_tx_pop && tx_empty;
        over_evt  = dev_rx_push && rx_full;
        rx_pop_ok = rd_rxq && !rx_empty;
    end

    byte_link_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (TXQ_DEPTH)
    ) u_txq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (wr_txq),
        .push_data (bus_wdata),
        .pop       (tx_pop_ok),
        .head      (dev_tx_data),
        .empty     (tx_empty),
        .full      (tx_full)
    );

    byte_link_fifo #(
        .WIDTH (BYTE_W),
        .DEPTH (RXQ_DEPTH)
    ) u_rxq (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (dev_rx_push),
        .push_data (dev_rx_data),
        .pop       (rx_pop_ok),
        .head      (rx_head),
        .empty     (rx_empty),
        .full      (rx_full)
    );

    byte_link_flags u_flags (
        .clk        (clk),
        .rst_n      (rst_n),
        .tx_written (wr_txq),
        .rx_taken   (rx_pop_ok),
        .clr        (clr),
        .tx_full    (tx_full),
        .rx_empty   (rx_empty),
        .under_evt  (under_evt),
        .over_evt   (over_evt),
        .flags      (flags)
    );

    // Hold the interrupt enable mask.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask <= '0;
        end else if (wr_mask) begin
            mask <= bus_wdata[NFLAGS-1:0];
        end
    end

    // Select read data for the addressed location; write-only reads as zero.
    always_comb begin
        status_bits = flags;
        bus_rdata   = '0;
        if (rd_any) begin
            case (loc_e'(bus_addr))
                LOC_CTRL: bus_rdata = {{PAD_W{1'b0}}, status_bits};
                LOC_RXQ:  bus_rdata = rx_empty ? '0 : rx_head;
                LOC_MASK: bus_rdata = {{PAD_W{1'b0}}, mask};
                default:  bus_rdata = '0;
            endcase
        end
    end

    // Combine enabled flags into the level interrupt.
    always_comb begin
        irq = |(status_bits & mask);
    end

endmodule

// File: rtl/byte_link_regs_chk.sv
// Module: byte_link_regs_chk
// Property checker for byte_link_regs, attached by bind below. Observes the
// bus, the device strobes, queue state and the flag word.
module byte_link_regs_chk
    import byte_link_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [BUS_AW-1:0] bus_addr,
    input logic [BYTE_W-1:0] bus_wdata,
    input logic              irq,
    input logic              dev_tx_pop,
    input logic              dev_rx_push,
    input logic              tx_empty,
    input logic              tx_full,
    input logic              rx_empty,
    input logic              rx_full,
    input logic [NFLAGS-1:0] status,
    input logic [NFLAGS-1:0] mask
);

    logic wr_ctrl;
    assign wr_ctrl = bus_sel && bus_wr && (bus_addr == LOC_CTRL);

    // R3: transmit write drops the room flag at the next edge
    a_r3_room_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && bus_wr && bus_addr == LOC_TXQ) |=> !status[0]);

    // R5: a taking read drops the data flag at the next edge
    a_r5_avail_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_sel && !bus_wr && bus_addr == LOC_RXQ && !rx_empty) |=> !status[1]);

    // R6, R9: underrun event always sets the flag, clear or not
    a_r6_underrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_tx_pop && tx_empty) |=> status[2]);

    // R7, R9: overrun event always sets the flag, clear or not
    a_r7_overrun_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_rx_push && rx_full) |=> status[3]);

    // R8: underrun flag holds without a write-1 clear
    a_r8_under_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[2] && !(wr_ctrl && bus_wdata[2])) |=> status[2]);

    // R8: overrun flag holds without a write-1 clear
    a_r8_over_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (status[3] && !(wr_ctrl && bus_wdata[3])) |=> status[3]);

    // R10: an interrupt needs an enabled, set flag
    a_r10_irq_source: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> ((status & mask) != '0));

    // R4: a queue is never full and empty at once
    a_r4_queue_sane: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_full && tx_empty) && !(rx_full && rx_empty));

endmodule

bind byte_link_regs byte_link_regs_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_sel     (bus_sel),
    .bus_wr      (bus_wr),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .irq         (irq),
    .dev_tx_pop  (dev_tx_pop),
    .dev_rx_push (dev_rx_push),
    .tx_empty    (tx_empty),
    .tx_full     (tx_full),
    .rx_empty    (rx_empty),
    .rx_full     (rx_full),
    .status      (status_bits),
    .mask        (mask)
);

// File: tb/byte_link_regs_test.sv
// Bench for byte_link_regs: a vector table walked by one loop, then directed
// tests for flag collisions, action clears and a mid-run reset.
module byte_link_regs_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_sel = 1'b0;
    logic       bus_wr = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       irq;
    logic       dev_tx_pop = 1'b0;
    logic [7:0] dev_tx_data;
    logic       dev_rx_push = 1'b0;
    logic [7:0] dev_rx_data = '0;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    byte_link_regs uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .irq         (irq),
        .dev_tx_pop  (dev_tx_pop),
        .dev_tx_data (dev_tx_data),
        .dev_rx_push (dev_rx_push),
        .dev_rx_data (dev_rx_data)
    );

    localparam logic [2:0] OP_IDLE = 3'd0; // nothing
    localparam logic [2:0] OP_WR   = 3'd1; // bus write addr,data
    localparam logic [2:0] OP_RD   = 3'd2; // bus read addr, expect data
    localparam logic [2:0] OP_POP  = 3'd3; // device pop, expect tx byte
    localparam logic [2:0] OP_POPX = 3'd4; // device pop, no data check
    localparam logic [2:0] OP_PUSH = 3'd5; // device push data

    typedef struct packed {
        logic [2:0] op;
        logic [1:0] addr;
        logic [7:0] data;
        logic       irq;
    } vec_t;

    localparam int NVEC = 53;
    localparam vec_t VEC [NVEC] = '{
        '{OP_RD,   2'd0, 8'h01, 1'b0}, // R1 status after reset
        '{OP_RD,   2'd3, 8'h00, 1'b0}, // R1 mask after reset
        '{OP_WR,   2'd1, 8'hA1, 1'b0}, // R4 push
        '{OP_RD,   2'd0, 8'h00, 1'b0}, // R3 room low after write
        '{OP_RD,   2'd0, 8'h01, 1'b0}, // R3 room back
        '{OP_WR,   2'd1, 8'hB2, 1'b0},
        '{OP_WR,   2'd1, 8'hC3, 1'b0},
        '{OP_WR,   2'd1, 8'hD4, 1'b0}, // queue full
        '{OP_IDLE, 2'd0, 8'h00, 1'b0},
        '{OP_RD,   2'd0, 8'h00, 1'b0}, // R3 full keeps room low
        '{OP_WR,   2'd1, 8'hE5, 1'b0}, // R4 dropped
        '{OP_POP,  2'd0, 8'hA1, 1'b0}, // R4 order
        '{OP_IDLE, 2'd0, 8'h00, 1'b0},
        '{OP_RD,   2'd0, 8'h01, 1'b0}, // R3 room after pop
        '{OP_POP,  2'd0, 8'hB2, 1'b0},
        '{OP_POP,  2'd0, 8'hC3, 1'b0},
        '{OP_POP,  2'd0, 8'hD4, 1'b0}, // R4 E5 never appeared
        '{OP_POPX, 2'd0, 8'h00, 1'b0}, // R6 pop while empty
        '{OP_RD,   2'd0, 8'h05, 1'b0}, // R6 underrun set
        '{OP_RD,   2'd0, 8'h05, 1'b0}, // R8 sticky
        '{OP_WR,   2'd0, 8'h00, 1'b0}, // R8 write 0
        '{OP_RD,   2'd0, 8'h05, 1'b0}, // R8 unchanged
        '{OP_WR,   2'd0, 8'h04, 1'b0}, // R8 clear underrun
        '{OP_RD,   2'd0, 8'h01, 1'b0}, // R8 cleared
        '{OP_PUSH, 2'd0, 8'h11, 1'b0},
        '{OP_IDLE, 2'd0, 8'h00, 1'b0},
        '{OP_RD,   2'd0, 8'h03, 1'b0}, // R5 data flag
        '{OP_PUSH, 2'd0, 8'h22, 1'b0},
        '{OP_PUSH, 2'd0, 8'h33, 1'b0},
        '{OP_PUSH, 2'd0, 8'h44, 1'b0}, // receive full
        '{OP_PUSH, 2'd0, 8'h55, 1'b0}, // R7 dropped
        '{OP_IDLE, 2'd0, 8'h00, 1'b0},
        '{OP_RD,   2'd0, 8'h0B, 1'b0}, // R7 overrun set
        '{OP_RD,   2'd2, 8'h11, 1'b0}, // R2 receive read
        '{OP_RD,   2'd0, 8'h09, 1'b0}, // R5 auto clear
        '{OP_RD,   2'd0, 8'h0B, 1'b0}, // R5 back
        '{OP_RD,   2'd2, 8'h22, 1'b0},
        '{OP_RD,   2'd2, 8'h33, 1'b0},
        '{OP_RD,   2'd2, 8'h44, 1'b0}, // R7 order, 55 gone
        '{OP_IDLE, 2'd0, 8'h00, 1'b0},
        '{OP_RD,   2'd0, 8'h09, 1'b0}, // R5 empty
        '{OP_RD,   2'd2, 8'h00, 1'b0}, // R11 empty read
        '{OP_RD,   2'd0, 8'h09, 1'b0}, // R11 no change
        '{OP_WR,   2'd0, 8'h08, 1'b0}, // R8 clear overrun
        '{OP_RD,   2'd0, 8'h01, 1'b0},
        '{OP_RD,   2'd1, 8'h00, 1'b0}, // R2 write-only reads 0
        '{OP_WR,   2'd3, 8'h02, 1'b0}, // R10 enable data flag
        '{OP_RD,   2'd3, 8'h02, 1'b0}, // R2 mask readback
        '{OP_PUSH, 2'd0, 8'h66, 1'b0},
        '{OP_IDLE, 2'd0, 8'h00, 1'b0},
        '{OP_RD,   2'd0, 8'h03, 1'b1}, // R10 irq up
        '{OP_RD,   2'd2, 8'h66, 1'b1}, // R10 still up this cycle
        '{OP_RD,   2'd0, 8'h01, 1'b0}  // R10 irq down
    };

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    // One cycle of stimulus: applied after the falling edge, settled by #1.
    task automatic step(input logic sel, input logic wr, input logic [1:0] a,
                        input logic [7:0] wd, input logic pop, input logic push,
                        input logic [7:0] pd);
        @(negedge clk);
        bus_sel     = sel;
        bus_wr      = wr;
        bus_addr    = a;
        bus_wdata   = wd;
        dev_tx_pop  = pop;
        dev_rx_push = push;
        dev_rx_data = pd;
        #1;
    endtask

    task automatic idle();
        step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
    endtask

    task automatic rd(input logic [1:0] a, input logic [7:0] exp, input string req);
        step(1'b1, 1'b0, a, 8'h00, 1'b0, 1'b0, 8'h00);
        check(req, bus_rdata, exp);
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        step(1'b1, 1'b1, a, d, 1'b0, 1'b0, 8'h00);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin : main
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        check("R1 irq", {7'd0, irq}, 8'h00);

        for (int i = 0; i < NVEC; i++) begin
            case (VEC[i].op)
                OP_WR:   step(1'b1, 1'b1, VEC[i].addr, VEC[i].data, 1'b0, 1'b0, 8'h00);
                OP_RD:   step(1'b1, 1'b0, VEC[i].addr, 8'h00, 1'b0, 1'b0, 8'h00);
                OP_POP:  step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00);
                OP_POPX: step(1'b0, 1'b0, 2'd0, 8'h00, 1'b1, 1'b0, 8'h00);
                OP_PUSH: step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, VEC[i].data);
                default: step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b0, 8'h00);
            endcase
            if (VEC[i].op == OP_RD)
                check($sformatf("vector %0d data", i), bus_rdata, VEC[i].data);
            if (VEC[i].op == OP_POP)
                check($sformatf("R4 vector %0d tx byte", i), dev_tx_data, VEC[i].data);
            check($sformatf("R10 vector %0d irq", i), {7'd0, irq}, {7'd0, VEC[i].irq});
        end

        // R3: write-1 to action bit 0 drops room for one cycle
        wr(2'd0, 8'h01);
        rd(2'd0, 8'h00, "R3 action clear room");
        rd(2'd0, 8'h01, "R3 room returns");

        // R9: underrun event and its clear in the same cycle
        step(1'b1, 1'b1, 2'd0, 8'h04, 1'b1, 1'b0, 8'h00);
        rd(2'd0, 8'h05, "R9 underrun set wins");
        wr(2'd0, 8'h04);
        rd(2'd0, 8'h01, "R8 underrun lone clear");

        // R9: overrun event and its clear in the same cycle
        for (int k = 0; k < 4; k++)
            step(1'b0, 1'b0, 2'd0, 8'h00, 1'b0, 1'b1, 8'h71 + 8'(k));
        idle();
        step(1'b1, 1'b1, 2'd0, 8'h08, 1'b0, 1'b1, 8'h99);
        rd(2'd0, 8'h0B, "R9 overrun set wins");
        check("R10 irq with data", {7'd0, irq}, 8'h01);
        wr(2'd0, 8'h08);
        rd(2'd0, 8'h03, "R8 overrun lone clear");

        // R1: reset in the middle of traffic
        @(negedge clk);
        rst_n = 1'b0;
        idle();
        idle();
        @(negedge clk);
        rst_n = 1'b1;
        rd(2'd0, 8'h01, "R1 status after mid reset");
        check("R1 irq after mid reset", {7'd0, irq}, 8'h00);
        rd(2'd3, 8'h00, "R1 mask after mid reset");
        rd(2'd2, 8'h00, "R1 receive queue empty");
        idle();

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule